// File: doc/BRIEF.md
# Synchronous Serial Port Status Flags

This block keeps the status word of a synchronous serial port. The transmit and receive datapaths send it single-cycle strobes: a word written into the transmit holding register, that word moved into the transmit shifter, the shifter finished, a word landed in the receive holding register, and that register read by software. Frame-sync and compare-match detectors send one event pulse each. The block turns these strobes into level flags and sticky event flags. It also shows the two enable levels.

Software reads the status through a strobe. One cycle after the strobe, the block returns a 32-bit snapshot with a valid pulse. The read also clears the sticky flags. An event that arrives in the same cycle as the read is kept for the next read. The returned word stays on the data port until the next read.

Top module: `ssp_status_word`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rd_valid` is 0 and `stat_rdata` is all zeros. Every flag starts cleared.
- R2: A `stat_rd` strobe in cycle N gives `rd_valid`=1 in cycle N+1 and loads `stat_rdata` with the status as it stood in cycle N. `stat_rdata` then holds that value until the next read. Bits 31:18, 15:12, 7:6 and 3:2 are always 0.
- R3: Bit 17 shows the `rx_en` level and bit 16 shows the `tx_en` level, both as sampled in the read cycle.
- R4: Bits 11, 10, 9 and 8 are sticky. They are set by `rx_sync_pulse`, `tx_sync_pulse`, `cmp1_pulse` and `cmp0_pulse` respectively. Each stays set until a status read.
- R5: A status read clears the sticky bits (11:8 and bit 5). An event pulse in the same cycle as the read does not show in that read's word, but the flag is set afterwards.
- R6: Bit 4 (receive ready) is 1 while the receive holding register holds unread data. `rhr_load` sets it. `rhr_read` clears it, unless `rhr_load` arrives in the same cycle.
- R7: Bit 5 (overrun) sets when `rhr_load` arrives while the holding register is full and no `rhr_read` arrives in that cycle. `rhr_read` does not clear it. Only a status read clears it.
- R8: Bit 0 (transmit ready) is 1 when the transmit holding register is empty. `thr_write` clears it from the next cycle. `tsr_load` sets it again, unless `thr_write` arrives in the same cycle.
- R9: Bit 1 (transmit empty) is 1 only when the holding register is empty and the shifter is idle. `tsr_load` makes the shifter busy. `tsr_done` makes it idle, unless `tsr_load` arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable level |
| tx_en | input | 1 | Transmitter enable level |
| rx_sync_pulse | input | 1 | Receive frame-sync event |
| tx_sync_pulse | input | 1 | Transmit frame-sync event |
| cmp1_pulse | input | 1 | Compare-1 match event |
| cmp0_pulse | input | 1 | Compare-0 match event |
| thr_write | input | 1 | Word written into the transmit holding register |
| tsr_load | input | 1 | Holding word moved into the transmit shifter |
| tsr_done | input | 1 | Shifter finished sending its word |
| rhr_load | input | 1 | Received word loaded into the receive holding register |
| rhr_read | input | 1 | Receive holding register read by software |
| stat_rd | input | 1 | Status word read strobe |
| rd_valid | output | 1 | Status data valid, one cycle after `stat_rd` |
| stat_rdata | output | 32 | Last status snapshot |

## Verification
The assertions assume that `tsr_load` only comes while the holding register is full and that `tsr_done` only comes while the shifter is busy. With these rules the transmit flags follow a real datapath. The random stimulus enforces the rules by gating these two strobes with the bench model's own holding and shifter state. Receive strobes, writes, events and reads are left unconstrained. This lets loads, reads, overruns and events collide in the same cycle as status reads.

// File: rtl/ssp_stat_pkg.sv
package ssp_stat_pkg;
  localparam int STAT_W     = 32;
  localparam int NUM_EVT    = 4;
  localparam int POS_RXEN   = 17;
  localparam int POS_TXEN   = 16;
  localparam int POS_EVT_LO = 8;
  localparam int POS_OVR    = 5;
  localparam int POS_RXRDY  = 4;
  localparam int POS_TXEMP  = 1;
  localparam int POS_TXRDY  = 0;

  typedef struct packed {
    logic               rx_en;
    logic               tx_en;
    logic [NUM_EVT-1:0] evt;
    logic               ovr;
    logic               rx_rdy;
    logic               tx_empty;
    logic               tx_rdy;
  } stat_fields_t;

  function automatic logic [STAT_W-1:0] pack_status(stat_fields_t f);
    logic [STAT_W-1:0] w;
    w = '0;
    w[POS_RXEN]                       = f.rx_en;
    w[POS_TXEN]                       = f.tx_en;
    w[POS_EVT_LO +: NUM_EVT]          = f.evt;
    w[POS_OVR]                        = f.ovr;
    w[POS_RXRDY]                      = f.rx_rdy;
    w[POS_TXEMP]                      = f.tx_empty;
    w[POS_TXRDY]                      = f.tx_rdy;
    return w;
  endfunction
endpackage

// File: rtl/ssp_sticky_bank.sv
module ssp_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;
      else if (clr_i)    q <= 1'b0;
    end
    assign flag_o[k] = q;
  end
endmodule

// File: rtl/ssp_tx_track.sv
module ssp_tx_track (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic load_i,
  input  logic done_i,
  output logic thr_full_o,
  output logic shift_busy_o,
  output logic tx_rdy_o,
  output logic tx_empty_o
);
  logic thr_full_q, busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_full_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (wr_i)        thr_full_q <= 1'b1;
      else if (load_i) thr_full_q <= 1'b0;
      if (load_i)      busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign thr_full_o   = thr_full_q;
  assign shift_busy_o = busy_q;
  assign tx_rdy_o     = ~thr_full_q;
  assign tx_empty_o   = ~thr_full_q & ~busy_q;
endmodule

// File: rtl/ssp_rx_track.sv
module ssp_rx_track (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic read_i,
  input  logic stat_rd_i,
  output logic rhr_full_o,
  output logic ovr_o
);
  logic full_q, ovr_q;
  logic ovr_hit;

  assign ovr_hit = load_i & full_q & ~read_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load_i)      full_q <= 1'b1;
      else if (read_i) full_q <= 1'b0;
      if (ovr_hit)        ovr_q <= 1'b1;
      else if (stat_rd_i) ovr_q <= 1'b0;
    end
  end

  assign rhr_full_o = full_q;
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/ssp_status_word.sv
module ssp_status_word
  import ssp_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              rx_sync_pulse,
  input  logic              tx_sync_pulse,
  input  logic              cmp1_pulse,
  input  logic              cmp0_pulse,
  input  logic              thr_write,
  input  logic              tsr_load,
  input  logic              tsr_done,
  input  logic              rhr_load,
  input  logic              rhr_read,
  input  logic              stat_rd,
  output logic              rd_valid,
  output logic [STAT_W-1:0] stat_rdata
);
  logic [NUM_EVT-1:0] evt_pulse;
  logic [NUM_EVT-1:0] sticky_q;
  logic thr_full, shift_busy, tx_rdy, tx_empty;
  logic rhr_full, ovr_q;
  stat_fields_t fields;

  // event order sets the bit order: rx sync at the top, compare 0 at the bottom
  assign evt_pulse = {rx_sync_pulse, tx_sync_pulse, cmp1_pulse, cmp0_pulse};

  ssp_sticky_bank #(.N(NUM_EVT)) u_sticky (
    .clk(clk), .rst(rst), .set_i(evt_pulse), .clr_i(stat_rd), .flag_o(sticky_q)
  );

  ssp_tx_track u_tx (
    .clk(clk), .rst(rst), .wr_i(thr_write), .load_i(tsr_load), .done_i(tsr_done),
    .thr_full_o(thr_full), .shift_busy_o(shift_busy),
    .tx_rdy_o(tx_rdy), .tx_empty_o(tx_empty)
  );

  ssp_rx_track u_rx (
    .clk(clk), .rst(rst), .load_i(rhr_load), .read_i(rhr_read), .stat_rd_i(stat_rd),
    .rhr_full_o(rhr_full), .ovr_o(ovr_q)
  );

  always_comb begin
    fields.rx_en    = rx_en;
    fields.tx_en    = tx_en;
    fields.evt      = sticky_q;
    fields.ovr      = ovr_q;
    fields.rx_rdy   = rhr_full;
    fields.tx_empty = tx_empty;
    fields.tx_rdy   = tx_rdy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      stat_rdata <= '0;
    end else begin
      rd_valid <= stat_rd;
      if (stat_rd) stat_rdata <= pack_status(fields);
    end
  end
endmodule

// File: rtl/ssp_status_chk.sv
module ssp_status_chk
  import ssp_stat_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               stat_rd,
  input logic               rd_valid,
  input logic [STAT_W-1:0]  stat_rdata,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [NUM_EVT-1:0] sticky_q,
  input logic               thr_write,
  input logic               tsr_load,
  input logic               tsr_done,
  input logic               thr_full,
  input logic               shift_busy,
  input logic               rhr_load,
  input logic               rhr_read,
  input logic               rhr_full,
  input logic               ovr_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!rd_valid && stat_rdata == '0));

  // R2
  read_reply_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_valid && stat_rdata[31:18] == '0 && stat_rdata[15:12] == '0
                 && stat_rdata[7:6] == '0 && stat_rdata[3:2] == '0));

  // R4
  event_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((sticky_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && evt_pulse == '0) |=> (sticky_q == '0));

  // R6
  rx_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (rhr_read && !rhr_load) |=> !rhr_full);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rhr_load && rhr_full && !rhr_read) |=> ovr_q);

  // R7
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !stat_rd) |=> ovr_q);

  // R8
  thr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    thr_write |=> thr_full);

  // R9
  shifter_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tsr_done && !tsr_load) |=> !shift_busy);

  // R9
  empty_implies_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && stat_rdata[1]) |-> stat_rdata[0]);
endmodule

bind ssp_status_word ssp_status_chk u_chk (.*);

// File: tb/sim_ssp_status_word.sv
`timescale 1ns/100ps
module sim_ssp_status_word;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 0, tx_en = 0;
  logic rx_sync_pulse = 0, tx_sync_pulse = 0, cmp1_pulse = 0, cmp0_pulse = 0;
  logic thr_write = 0, tsr_load = 0, tsr_done = 0, rhr_load = 0, rhr_read = 0, stat_rd = 0;
  logic rd_valid;
  logic [31:0] stat_rdata;

  always #2.5 clk = ~clk;

  ssp_status_word u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  bit [3:0] m_evt;
  bit m_ovr, m_rfull, m_tfull, m_busy, m_valid;
  bit [31:0] m_data;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_evt = 0; m_ovr = 0; m_rfull = 0; m_tfull = 0; m_busy = 0;
    m_valid = 0; m_data = 0;
  endtask

  task automatic compare_all();
    chk("R2 valid", {31'b0, rd_valid}, {31'b0, m_valid});
    chk("R2 unused", stat_rdata & 32'hFFFC_F0CC, 32'h0);
    chk("R3 enables", stat_rdata & 32'h0003_0000, m_data & 32'h0003_0000);
    chk("R4 events", stat_rdata & 32'h0000_0F00, m_data & 32'h0000_0F00);
    chk("R7 overrun", stat_rdata & 32'h20, m_data & 32'h20);
    chk("R6 rxready", stat_rdata & 32'h10, m_data & 32'h10);
    chk("R9 txempty", stat_rdata & 32'h2, m_data & 32'h2);
    chk("R8 txready", stat_rdata & 32'h1, m_data & 32'h1);
  endtask

  // advance one clock with the inputs as currently driven
  task automatic step();
    bit [3:0] ev;
    bit [31:0] snap;
    ev = {rx_sync_pulse, tx_sync_pulse, cmp1_pulse, cmp0_pulse};
    snap = 0;
    snap[17] = rx_en; snap[16] = tx_en;
    snap[11:8] = m_evt; snap[5] = m_ovr; snap[4] = m_rfull;
    snap[1] = !m_tfull && !m_busy; snap[0] = !m_tfull;
    @(posedge clk);
    #1;
    m_valid = stat_rd;
    if (stat_rd) m_data = snap;
    m_ovr   = (rhr_load && m_rfull && !rhr_read) || (m_ovr && !stat_rd);
    m_evt   = ev | (stat_rd ? 4'b0 : m_evt);
    m_rfull = rhr_load || (m_rfull && !rhr_read);
    m_tfull = thr_write || (m_tfull && !tsr_load);
    m_busy  = tsr_load || (m_busy && !tsr_done);
    compare_all();
    {rx_sync_pulse, tx_sync_pulse, cmp1_pulse, cmp0_pulse} = 4'b0;
    {thr_write, tsr_load, tsr_done, rhr_load, rhr_read, stat_rd} = 6'b0;
  endtask

  task automatic read_status();
    stat_rd = 1; step();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: held in reset
    chk("R1 valid", {31'b0, rd_valid}, 32'h0);
    chk("R1 data", stat_rdata, 32'h0);
    rst = 0;
    step();
    chk("R1 after release", stat_rdata, 32'h0);

    // R2 R8 R9: idle read shows both transmit flags set
    read_status();
    chk("R2 idle word", stat_rdata, 32'h0000_0003);

    // R3: enable levels
    rx_en = 1; tx_en = 0; read_status();
    chk("R3 rx only", stat_rdata, 32'h0002_0003);
    rx_en = 0; tx_en = 1; read_status();
    chk("R3 tx only", stat_rdata, 32'h0001_0003);
    tx_en = 0;

    // R4: events stick across idle cycles
    rx_sync_pulse = 1; step();
    cmp0_pulse = 1; step();
    step(); step();
    read_status();
    chk("R4 sticky", stat_rdata, 32'h0000_0903);
    read_status();
    chk("R5 cleared by read", stat_rdata, 32'h0000_0003);

    // R5: event during read is kept
    cmp1_pulse = 1; stat_rd = 1; step();
    chk("R5 not in same read", stat_rdata, 32'h0000_0003);
    read_status();
    chk("R5 retained", stat_rdata, 32'h0000_0203);

    // R6 R7: double load gives overrun, software read leaves it
    rhr_load = 1; step();
    rhr_load = 1; step();
    rhr_read = 1; step();
    read_status();
    chk("R7 overrun survives rhr_read", stat_rdata, 32'h0000_0023);
    read_status();
    chk("R7 cleared by status read", stat_rdata, 32'h0000_0003);
    // load with read in same cycle: no overrun
    rhr_load = 1; step();
    rhr_load = 1; rhr_read = 1; step();
    read_status();
    chk("R6 load with read", stat_rdata, 32'h0000_0013);
    rhr_read = 1; step();

    // R8 R9: transmit sequence
    thr_write = 1; step();
    read_status();
    chk("R8 written", stat_rdata, 32'h0000_0000);
    tsr_load = 1; step();
    read_status();
    chk("R9 shifting", stat_rdata, 32'h0000_0001);
    tsr_done = 1; step();
    read_status();
    chk("R9 drained", stat_rdata, 32'h0000_0003);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 50 == 0) rx_en = ~rx_en;
      if ($urandom % 50 == 0) tx_en = ~tx_en;
      if ($urandom % 4 == 0)
        {rx_sync_pulse, tx_sync_pulse, cmp1_pulse, cmp0_pulse} = 4'($urandom);
      thr_write = ($urandom % 5 == 0);
      tsr_load  = m_tfull && ($urandom % 3 == 0);
      tsr_done  = m_busy && ($urandom % 3 == 0);
      rhr_load  = ($urandom % 4 == 0);
      rhr_read  = ($urandom % 4 == 0);
      stat_rd   = ($urandom % 3 == 0);
      step();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule